// File: doc/BRIEF.md
# Triggered 1-0-1 Burst Generator

This block is a small synchronous Moore machine that answers a level trigger with a fixed three-bit serial burst. When it is idle and finds the trigger input high at a rising clock edge, it drives the serial output with a one, then a zero, then a one. Each bit lasts exactly one clock period. Every burst state has its own output value, so the serial bit is decoded from the state register alone.

After the third bit the machine will not start again until the trigger has been seen low. If the trigger is still high at the last bit, the machine parks in a waiting state with the output low. If the trigger is already low, it goes straight back to idle. A busy flag covers the whole time from the first bit to the return to idle, so a consumer can tell a live burst or a pending rearm from true idle.

Top module: `g101_burst`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) puts the machine in idle. In the cycle after that edge, `sout` and `busy` are both 0.
- R2: While idle with `s` low at each edge, `sout` and `busy` stay 0.
- R3: If idle and `s` is high at an edge, `sout` is 1 and `busy` is 1 in the cycle right after that edge.
- R4: The burst is `sout` = 1, 0, 1 on three consecutive clock cycles, each bit lasting exactly one clock period.
- R5: The value of `s` during the first and second bit cycles has no effect on the burst.
- R6: If `s` is high at the edge that ends the third bit, the machine waits with `sout` 0 and `busy` 1 for as long as `s` stays high.
- R7: The machine returns to idle (`busy` 0) only at an edge where `s` is low. This happens either at the end of the third bit or from the waiting state. A new burst can then start at the very next edge where `s` is high.
- R8: `busy` is 1 from the first bit until the return to idle, and `sout` is never 1 while `busy` is 0.
- R9: Holding `s` high for many cycles gives exactly one burst: two cycles with `sout` high in total.
- R10: A reset during a burst or while waiting aborts it, and the machine is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock |
| rst  | input  | 1 | Synchronous active-high reset |
| s    | input  | 1 | Level trigger; must be seen low before the machine rearms |
| sout | output | 1 | Serial burst bit (Moore output) |
| busy | output | 1 | High from the first burst bit until the machine is idle again |

## Verification
A wrong state shows up on the ports within one cycle. A skipped or repeated bit state breaks the 1-0-1 shape of `sout` on the very next cycle. A missing wait state shows as a second burst while `s` is still held high. An early return to idle drops `busy` at an edge where `s` was high. The bench therefore sweeps every 8-cycle trigger pattern from reset and compares `sout` and `busy` on every cycle against a phase counter that it keeps from the requirements. This catches each such fault on the cycle where it first appears.

// File: rtl/g101_pkg.sv
package g101_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BIT1 = 3'd1,
    ST_BIT2 = 3'd2,
    ST_BIT3 = 3'd3,
    ST_HOLD = 3'd4
  } g101_state_t;

  // Serial bit owned by each state (Moore decode).
  function automatic logic state_bit(input g101_state_t st);
    case (st)
      ST_BIT1, ST_BIT3: state_bit = 1'b1;
      default:          state_bit = 1'b0;
    endcase
  endfunction

  // Machine is occupied in every state except idle.
  function automatic logic state_busy(input g101_state_t st);
    state_busy = (st != ST_IDLE);
  endfunction

  // Successor along the fixed burst path, ignoring the trigger.
  function automatic g101_state_t burst_succ(input g101_state_t st);
    case (st)
      ST_BIT1: burst_succ = ST_BIT2;
      ST_BIT2: burst_succ = ST_BIT3;
      default: burst_succ = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/g101_next.sv
module g101_next
  import g101_pkg::*;
(
  input  g101_state_t cur,
  input  logic        trig,
  output g101_state_t nxt,
  output logic        fire,
  output logic        rearm,
  output logic        last_bit
);

  always_comb begin
    nxt      = cur;
    fire     = 1'b0;
    rearm    = 1'b0;
    last_bit = 1'b0;
    case (cur)
      ST_IDLE: begin
        if (trig) begin
          nxt  = ST_BIT1;
          fire = 1'b1;
        end
      end
      ST_BIT1, ST_BIT2: nxt = burst_succ(cur);
      ST_BIT3: begin
        last_bit = 1'b1;
        if (trig) begin
          nxt = ST_HOLD;
        end else begin
          nxt   = ST_IDLE;
          rearm = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!trig) begin
          nxt   = ST_IDLE;
          rearm = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/g101_state.sv
module g101_state
  import g101_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  g101_state_t nxt,
  output g101_state_t cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cur == ST_IDLE);  // R1
  AST_ZERO_AFTER_ONE: assert property (@(posedge clk) disable iff (rst)
    cur == ST_BIT2 |-> $past(cur) == ST_BIT1);  // R4
  AST_ONE_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    cur == ST_BIT3 |-> $past(cur) == ST_BIT2);  // R4
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    cur == ST_BIT1 |-> $past(cur) == ST_IDLE);  // R3

endmodule

// File: rtl/g101_decode.sv
module g101_decode
  import g101_pkg::*;
(
  input  g101_state_t cur,
  output logic        sout,
  output logic        busy,
  output logic        waiting
);

  always_comb begin
    sout    = state_bit(cur);
    busy    = state_busy(cur);
    waiting = (cur == ST_HOLD);
  end

endmodule

// File: rtl/g101_burst.sv
module g101_burst
  import g101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s,
  output logic sout,
  output logic busy
);

  g101_state_t cur_w;
  g101_state_t nxt_w;
  logic        fire_w;
  logic        rearm_w;
  logic        last_w;
  logic        wait_w;

  g101_next u_next (
    .cur      (cur_w),
    .trig     (s),
    .nxt      (nxt_w),
    .fire     (fire_w),
    .rearm    (rearm_w),
    .last_bit (last_w)
  );

  g101_state u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_w),
    .cur (cur_w)
  );

  g101_decode u_decode (
    .cur     (cur_w),
    .sout    (sout),
    .busy    (busy),
    .waiting (wait_w)
  );

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
    fire_w |=> sout && busy);  // R3
  AST_MID_LOW: assert property (@(posedge clk) disable iff (rst)
    (sout && $past(fire_w)) |=> !sout && busy);  // R4
  AST_LAST_HIGH: assert property (@(posedge clk) disable iff (rst)
    last_w |-> sout && busy);  // R4
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wait_w && s) |=> busy && !sout);  // R6
  AST_REARM_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> !$past(s));  // R7
  AST_REARM_EVENT: assert property (@(posedge clk) disable iff (rst)
    rearm_w |=> !busy);  // R7
  AST_OUT_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    sout |-> busy);  // R8

endmodule

// File: tb/sim_g101_burst.sv
module sim_g101_burst;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s   = 1'b0;
  logic sout;
  logic busy;

  int total = 0;
  int fails = 0;
  bit done  = 0;
  int phase = 0;  // 0 idle, 1..3 burst bits, 4 waiting

  always #5 clk = ~clk;

  g101_burst u0 (.clk(clk), .rst(rst), .s(s), .sout(sout), .busy(busy));

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at falling edge, model at rising edge, sample 1 ns later.
  task automatic step(input logic r, input logic sv);
    @(negedge clk);
    rst = r;
    s   = sv;
    @(posedge clk);
    if (r) phase = 0;
    else begin
      case (phase)
        0:       phase = sv ? 1 : 0;
        1:       phase = 2;
        2:       phase = 3;
        default: phase = sv ? 4 : 0;
      endcase
    end
    #1;
  endtask

  function automatic logic exp_out();
    return (phase == 1 || phase == 3);
  endfunction

  function automatic logic exp_busy();
    return (phase != 0);
  endfunction

  function automatic string tag_of(input logic r);
    if (r)          return "R1";
    if (phase == 4) return "R6";
    if (phase != 0) return "R4";
    return "R7";
  endfunction

  task automatic chk_model(input logic r);
    chk({tag_of(r), " sout"}, sout, exp_out());
    chk({"R8 busy"}, busy, exp_busy());
  endtask

  initial begin
    // R1: reset state
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R1 sout", sout, 1'b0);
    chk("R1 busy", busy, 1'b0);

    // R2: idle stays quiet
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0);
      chk("R2 sout", sout, 1'b0);
      chk("R2 busy", busy, 1'b0);
    end

    // R3, R4, R5: trigger then toggle s during first two bits
    step(1'b0, 1'b1);
    chk("R3 sout", sout, 1'b1);
    chk("R3 busy", busy, 1'b1);
    step(1'b0, 1'b0);
    chk("R5 sout bit2", sout, 1'b0);
    step(1'b0, 1'b1);
    chk("R5 sout bit3", sout, 1'b1);
    step(1'b0, 1'b0);
    chk("R7 busy", busy, 1'b0);
    // R7: immediate retrigger
    step(1'b0, 1'b1);
    chk("R7 retrigger", sout, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk("R6 sout", sout, 1'b0);
    chk("R6 busy", busy, 1'b1);
    // R10: reset while waiting
    step(1'b1, 1'b1);
    chk("R10 busy", busy, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R10 mid-burst busy", busy, 1'b0);
    chk("R10 mid-burst sout", sout, 1'b0);

    // R9: long hold gives exactly one burst
    step(1'b1, 1'b0);
    begin
      int highs = 0;
      int rises = 0;
      logic prev_b = 1'b0;
      for (int i = 0; i < 60; i++) begin
        step(1'b0, 1'b1);
        if (sout) highs++;
        if (busy && !prev_b) rises++;
        prev_b = busy;
      end
      chk("R9 two high bits", (highs == 2), 1'b1);
      chk("R9 single start", (rises == 1), 1'b1);
      chk("R9 still waiting", busy, 1'b1);
    end
    step(1'b0, 1'b0);
    chk("R7 leave wait", busy, 1'b0);

    // Sweep every 8-cycle trigger pattern from reset against the phase model
    for (int p = 0; p < 256; p++) begin
      step(1'b1, 1'b0);
      chk_model(1'b1);
      for (int i = 0; i < 8; i++) begin
        step(1'b0, p[i]);
        chk_model(1'b0);
      end
      for (int i = 0; i < 3; i++) begin
        step(1'b0, 1'b0);
        chk_model(1'b0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule